// File: doc/BRIEF.md
# Hash Block MAC Accumulator

This block computes a keyed digest over each straight-line instruction group while the group's instructions retire. It takes one committed 32-bit instruction word per cycle. A marker instruction opens a group and a control-flow instruction closes it, and both of these words are part of the group. The block packs the words four at a time into 128-bit chunks and pads the last chunk of a group with zero words. Each chunk goes through a pipelined keyed-mixing stage that has a fixed latency of `LAT` cycles and accepts one chunk per cycle. The block XOR-folds the mixed chunks of a group into a running 128-bit value and presents the finished digest with a one-cycle valid strobe. The digest carries the index taken from the group's marker.

Only committed words may be presented, so speculative or nullified instructions never enter a digest. The mixing stage is a placeholder for a real block cipher. It has the same latency and throughput and computes rotate-left((chunk XOR KEY), ROT). For an interrupt or a context switch, the whole accumulator state can be read out as one opaque word and later loaded back. A save waits until no chunk is still inside the mixing pipeline.

Top module: `hbm_mac_accum`

## Requirements
- R1: Words of a group fill chunk lanes in commit order. The first word of a chunk occupies bits [31:0] and the fourth occupies bits [127:96]. Unfilled lanes of a group's final chunk are zero.
- R2: The digest is the XOR over all chunks c of the group of rotl128(c XOR KEY, ROT).
- R3: `in_kind` = 1 marks a marker word. The marker word is the first word of the group, and `out_tag` equals the marker word bits [TAG_W-1:0].
- R4: `in_kind` = 2 marks the exit word. The exit word is the last word of the group and closes it. The digest appears with `out_valid` high for exactly one cycle, `LAT` rising edges after the edge that sampled the exit word.
- R5: Words sampled with `in_valid` low have no effect. Words of kind 0, 2 or 3 that arrive while no group is open also have no effect.
- R6: A marker that arrives while a group is open abandons that group. The abandoned group produces no digest, and the new group's digest does not depend on the abandoned group's words.
- R7: Groups may follow each other with no idle cycles. Every digest leaves in commit order, even while chunks of several groups are inside the pipeline.
- R8: While `ctx_save` is high and chunks are inside the pipeline, `ctx_busy` is high and no save takes place. Once the pipeline is empty, the request is accepted and `ctx_vld` pulses on the next cycle with the state in `ctx_out`.
- R9: Loading a saved state through `ctx_load`/`ctx_in` while the pipeline is empty resumes the interrupted group, so its digest equals the uninterrupted result.
- R10: Reset leaves no group open, with `out_valid`, `ctx_vld` and `ctx_busy` low, and a group cut by reset produces no digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A committed instruction word is present |
| in_kind | input | 2 | 0 plain, 1 marker, 2 exit, 3 plain |
| in_word | input | 32 | Committed instruction word |
| out_valid | output | 1 | Digest strobe |
| out_digest | output | 128 | Finished group digest |
| out_tag | output | TAG_W | Index from the group's marker |
| ctx_save | input | 1 | Save request |
| ctx_busy | output | 1 | Save held off while chunks are inside the pipeline |
| ctx_vld | output | 1 | Saved state valid on `ctx_out` |
| ctx_out | output | CTX_W | Saved accumulator state |
| ctx_load | input | 1 | Load `ctx_in` into the accumulator state |
| ctx_in | input | CTX_W | State to restore |

## Verification
A digest is due `LAT` rising edges after the edge that samples its exit word. For every exit it drives, the bench records the cycle number plus 1 plus `LAT` and queues that value together with the arithmetically computed digest and tag. Each digest seen at a falling edge is compared with the queue head, both in value and in arrival cycle. `ctx_busy` is combinational from the request, so it is sampled a moment after the request is driven. `ctx_vld` is checked one falling edge after the accepting edge. At the end an empty queue shows that abandoned, reset-cut and ignored input produced nothing.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 4;
  localparam int CHUNK_W = WORD_W * LANES;
  localparam int LANE_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_MARK  = 2'd1,
    K_EXIT  = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;

  // placeholder keyed mixing: rotate-left of (x ^ key)
  function automatic logic [CHUNK_W-1:0] hbm_mix(input logic [CHUNK_W-1:0] x,
                                                  input logic [CHUNK_W-1:0] key,
                                                  input int rot);
    logic [CHUNK_W-1:0] t;
    t = x ^ key;
    if (rot == 0) return t;
    return (t << rot) | (t >> (CHUNK_W - rot));
  endfunction
endpackage

// File: rtl/hbm_packer.sv
module hbm_packer import hbm_pkg::*; #(
  parameter int TAG_W = 8,
  localparam int PK_W = 2 + LANE_W + (LANES-1)*WORD_W + TAG_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_kind,
  input  logic [WORD_W-1:0]  in_word,
  input  logic               ld,
  input  logic [PK_W-1:0]    ld_state,
  output logic [PK_W-1:0]    st,
  output logic               iss_vld,
  output logic               iss_first,
  output logic               iss_last,
  output logic [TAG_W-1:0]   iss_tag,
  output logic [CHUNK_W-1:0] iss_chunk
);
  logic                           open_q, first_q;
  logic [LANE_W-1:0]              lane_q;
  logic [LANES-2:0][WORD_W-1:0]   buf_q;
  logic [TAG_W-1:0]               tag_q;

  logic is_mark, is_exit, take, full;
  assign is_mark = in_valid && !ld && (in_kind == K_MARK);
  assign is_exit = (in_kind == K_EXIT);
  assign take    = in_valid && !ld && !is_mark && open_q;
  assign full    = (lane_q == LANE_W'(LANES-1));

  assign iss_vld   = take && (full || is_exit);
  assign iss_first = first_q;
  assign iss_last  = is_exit;
  assign iss_tag   = tag_q;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    if (j < LANES-1) begin : g_held
      assign iss_chunk[j*WORD_W +: WORD_W] =
        (LANE_W'(j) < lane_q)  ? buf_q[j] :
        (LANE_W'(j) == lane_q) ? in_word  : '0;
    end else begin : g_top
      assign iss_chunk[j*WORD_W +: WORD_W] = (LANE_W'(j) == lane_q) ? in_word : '0;
    end
  end

  assign st = {tag_q, buf_q, lane_q, first_q, open_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      first_q <= 1'b0;
      lane_q  <= '0;
      buf_q   <= '0;
      tag_q   <= '0;
    end else if (ld) begin
      {tag_q, buf_q, lane_q, first_q, open_q} <= ld_state;
    end else if (is_mark) begin
      open_q   <= 1'b1;
      first_q  <= 1'b1;
      tag_q    <= in_word[TAG_W-1:0];
      buf_q[0] <= in_word;
      lane_q   <= LANE_W'(1);
    end else if (take) begin
      if (full || is_exit) begin
        lane_q  <= '0;
        first_q <= 1'b0;
        if (is_exit) open_q <= 1'b0;
      end else begin
        buf_q[lane_q] <= in_word;
        lane_q        <= lane_q + LANE_W'(1);
      end
    end
  end
endmodule

// File: rtl/hbm_cipher_pipe.sv
module hbm_cipher_pipe import hbm_pkg::*; #(
  parameter int                 LAT   = 20,
  parameter int                 TAG_W = 8,
  parameter int                 ROT   = 13,
  parameter logic [CHUNK_W-1:0] KEY   = '0
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               i_vld,
  input  logic               i_first,
  input  logic               i_last,
  input  logic [TAG_W-1:0]   i_tag,
  input  logic [CHUNK_W-1:0] i_chunk,
  output logic               o_vld,
  output logic               o_first,
  output logic               o_last,
  output logic [TAG_W-1:0]   o_tag,
  output logic [CHUNK_W-1:0] o_data
);
  localparam int PW = 2 + TAG_W + CHUNK_W;

  logic [LAT-1:0]         v_q;
  logic [LAT-1:0][PW-1:0] d_q;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) v_q[0] <= 1'b0;
        else     v_q[0] <= i_vld;
      end
      always_ff @(posedge clk)
        d_q[0] <= {i_first, i_last, i_tag, hbm_mix(i_chunk, KEY, ROT)};
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) v_q[s] <= 1'b0;
        else     v_q[s] <= v_q[s-1];
      end
      always_ff @(posedge clk)
        d_q[s] <= d_q[s-1];
    end
  end

  assign o_vld = v_q[LAT-1];
  assign {o_first, o_last, o_tag, o_data} = d_q[LAT-1];
endmodule

// File: rtl/hbm_fold.sv
module hbm_fold import hbm_pkg::*; #(
  parameter int TAG_W = 8
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               p_vld,
  input  logic               p_first,
  input  logic               p_last,
  input  logic [TAG_W-1:0]   p_tag,
  input  logic [CHUNK_W-1:0] p_data,
  input  logic               ld,
  input  logic [CHUNK_W-1:0] ld_acc,
  output logic [CHUNK_W-1:0] acc,
  output logic               dig_vld,
  output logic [CHUNK_W-1:0] dig,
  output logic [TAG_W-1:0]   dig_tag
);
  logic [CHUNK_W-1:0] nxt;
  assign nxt = (p_first ? '0 : acc) ^ p_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      dig_vld <= 1'b0;
      dig     <= '0;
      dig_tag <= '0;
    end else begin
      dig_vld <= 1'b0;
      if (ld) begin
        acc <= ld_acc;
      end else if (p_vld) begin
        if (p_last) begin
          acc     <= '0;
          dig     <= nxt;
          dig_tag <= p_tag;
          dig_vld <= 1'b1;
        end else begin
          acc <= nxt;
        end
      end
    end
  end
endmodule

// File: rtl/hbm_mac_accum.sv
module hbm_mac_accum import hbm_pkg::*; #(
  parameter int                 LAT   = 20,
  parameter int                 TAG_W = 8,
  parameter int                 ROT   = 13,
  parameter logic [CHUNK_W-1:0] KEY   = 128'h3c1f_9a07_e265_d4b8_5f0a_71c3_a9e4_2b6d,
  localparam int PK_W  = 2 + LANE_W + (LANES-1)*WORD_W + TAG_W,
  localparam int CTX_W = PK_W + CHUNK_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [1:0]         in_kind,
  input  logic [WORD_W-1:0]  in_word,
  output logic               out_valid,
  output logic [CHUNK_W-1:0] out_digest,
  output logic [TAG_W-1:0]   out_tag,
  input  logic               ctx_save,
  output logic               ctx_busy,
  output logic               ctx_vld,
  output logic [CTX_W-1:0]   ctx_out,
  input  logic               ctx_load,
  input  logic [CTX_W-1:0]   ctx_in
);
  localparam int CNT_W = $clog2(LAT + 1);

  logic [PK_W-1:0]    pk_st;
  logic               iss_vld, iss_first, iss_last;
  logic [TAG_W-1:0]   iss_tag;
  logic [CHUNK_W-1:0] iss_chunk;
  logic               p_vld, p_first, p_last;
  logic [TAG_W-1:0]   p_tag;
  logic [CHUNK_W-1:0] p_data, acc;
  logic [CNT_W-1:0]   occ_q;
  logic               accept;

  hbm_packer #(.TAG_W(TAG_W)) u_pack (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_word(in_word),
    .ld(ctx_load), .ld_state(ctx_in[PK_W-1:0]), .st(pk_st),
    .iss_vld(iss_vld), .iss_first(iss_first), .iss_last(iss_last),
    .iss_tag(iss_tag), .iss_chunk(iss_chunk));

  hbm_cipher_pipe #(.LAT(LAT), .TAG_W(TAG_W), .ROT(ROT), .KEY(KEY)) u_pipe (
    .clk(clk), .rst(rst), .i_vld(iss_vld), .i_first(iss_first), .i_last(iss_last),
    .i_tag(iss_tag), .i_chunk(iss_chunk), .o_vld(p_vld), .o_first(p_first),
    .o_last(p_last), .o_tag(p_tag), .o_data(p_data));

  hbm_fold #(.TAG_W(TAG_W)) u_fold (
    .clk(clk), .rst(rst), .p_vld(p_vld), .p_first(p_first), .p_last(p_last),
    .p_tag(p_tag), .p_data(p_data), .ld(ctx_load), .ld_acc(ctx_in[CTX_W-1 -: CHUNK_W]),
    .acc(acc), .dig_vld(out_valid), .dig(out_digest), .dig_tag(out_tag));

  assign ctx_busy = ctx_save && (occ_q != '0);
  assign accept   = ctx_save && (occ_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q   <= '0;
      ctx_vld <= 1'b0;
      ctx_out <= '0;
    end else begin
      occ_q   <= occ_q + CNT_W'(iss_vld) - CNT_W'(p_vld);
      ctx_vld <= accept;
      if (accept) ctx_out <= {acc, pk_st};
    end
  end
endmodule

// File: rtl/hbm_mac_accum_chk.sv
module hbm_mac_accum_chk #(
  parameter int LAT   = 20,
  parameter int CNT_W = 5
)(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             ctx_save,
  input logic             ctx_busy,
  input logic             ctx_vld,
  input logic             ctx_load,
  input logic             out_valid,
  input logic [CNT_W-1:0] occ_q
);
  // R8
  save_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (ctx_save && !ctx_busy) |=> ctx_vld);
  // R8
  save_held_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_busy |=> !ctx_vld);
  // R8
  save_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ctx_vld |-> $past(ctx_save));
  // R4
  out_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(occ_q != '0));
  // R7
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CNT_W'(LAT));
  // R5
  idle_growth_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !ctx_load) |=> occ_q <= $past(occ_q));
endmodule

bind hbm_mac_accum hbm_mac_accum_chk #(.LAT(LAT), .CNT_W($clog2(LAT + 1))) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ctx_save(ctx_save), .ctx_busy(ctx_busy),
  .ctx_vld(ctx_vld), .ctx_load(ctx_load), .out_valid(out_valid), .occ_q(occ_q));

// File: tb/hbm_mac_accum_tb.sv
`timescale 1ns/100ps
module hbm_mac_accum_tb;
  localparam int LAT   = 20;
  localparam int TAG_W = 8;
  localparam int ROT   = 13;
  localparam logic [127:0] KEY = 128'h3c1f_9a07_e265_d4b8_5f0a_71c3_a9e4_2b6d;
  localparam int CTX_W = 2 + 2 + 96 + TAG_W + 128;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [31:0] in_word = '0;
  logic out_valid, ctx_busy, ctx_vld;
  logic [127:0] out_digest;
  logic [TAG_W-1:0] out_tag;
  logic ctx_save = 1'b0, ctx_load = 1'b0;
  logic [CTX_W-1:0] ctx_out, ctx_in = '0, snap;

  always #2.5 clk = ~clk;

  hbm_mac_accum #(.LAT(LAT), .TAG_W(TAG_W), .ROT(ROT), .KEY(KEY)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_word(in_word),
    .out_valid(out_valid), .out_digest(out_digest), .out_tag(out_tag),
    .ctx_save(ctx_save), .ctx_busy(ctx_busy), .ctx_vld(ctx_vld), .ctx_out(ctx_out),
    .ctx_load(ctx_load), .ctx_in(ctx_in));

  int total = 0, bad = 0, cyc = 0;
  logic [127:0] e_dig [0:63];
  logic [TAG_W-1:0] e_tag [0:63];
  int e_cyc [0:63];
  int e_wr = 0, e_rd = 0;
  logic [31:0] gw [0:31];
  int gn = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] enc(input logic [127:0] x);
    logic [127:0] t;
    t = x ^ KEY;
    return (t << ROT) | (t >> (128 - ROT));
  endfunction

  // R1 R2: lanes from the low end, zero padding, XOR of mixed chunks
  function automatic logic [127:0] model_digest();
    logic [127:0] a, ch;
    int lane;
    a = '0; ch = '0; lane = 0;
    for (int i = 0; i < gn; i++) begin
      ch[lane*32 +: 32] = gw[i];
      lane++;
      if (lane == 4) begin a ^= enc(ch); ch = '0; lane = 0; end
    end
    if (lane != 0) a ^= enc(ch);
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drv(input logic [1:0] k, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_word = w;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0; in_kind = 2'd1; in_word = 32'hDEAD_BE01;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] mid_word(input logic [7:0] t, input int i);
    return {t, 8'(i), 8'h3C ^ t, 8'(i * 7 + 1)};
  endfunction

  task automatic begin_group(input logic [7:0] t);
    gn = 0;
    gw[gn] = {8'h4D, t, 8'h00, t}; gn++;
    drv(2'd1, gw[gn-1]);
  endtask

  task automatic add_mid(input logic [7:0] t, input int i);
    gw[gn] = mid_word(t, i); gn++;
    drv((i % 2 == 0) ? 2'd0 : 2'd3, gw[gn-1]);
  endtask

  task automatic end_group(input logic [7:0] t);
    gw[gn] = {8'hE7, t, 8'(gn), 8'h11}; gn++;
    drv(2'd2, gw[gn-1]);
    e_dig[e_wr % 64] = model_digest();
    e_tag[e_wr % 64] = t;
    e_cyc[e_wr % 64] = cyc + 1 + LAT;   // R4: LAT edges after the sampling edge
    e_wr++;
  endtask

  task automatic run_group(input logic [7:0] t, input int nmid);
    begin_group(t);
    for (int i = 0; i < nmid; i++) add_mid(t, i);
    end_group(t);
  endtask

  // monitor: every digest compared in order, value and arrival cycle
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (e_rd == e_wr) begin
        check(1'b0, "R6", "unexpected digest", out_digest, '0);
      end else begin
        check(out_digest == e_dig[e_rd % 64] && out_tag == e_tag[e_rd % 64], "R2 R3 R7",
              "digest/tag", {out_tag, out_digest[119:0]},
              {e_tag[e_rd % 64], e_dig[e_rd % 64][119:0]});
        check(cyc == e_cyc[e_rd % 64], "R4", "arrival cycle", 128'(cyc), 128'(e_cyc[e_rd % 64]));
        e_rd++;
      end
    end
  end

  initial begin
    while (cyc < 20000) @(posedge clk);
    check(1'b0, "R4", "watchdog expired", 128'(cyc), 128'(20000));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!out_valid && !ctx_vld && !ctx_busy, "R10", "reset outputs",
          {out_valid, ctx_vld, ctx_busy}, '0);

    // R1 R2 R7: every length 2..12 words back to back (all padding amounts)
    for (int n = 0; n <= 10; n++) run_group(8'(n + 1), n);
    idle(LAT + 4);

    // R5: stray words with no open group, and masked words
    drv(2'd0, 32'h1111_2222); drv(2'd2, 32'h3333_4444); drv(2'd3, 32'h5555_6666);
    idle(3);
    begin_group(8'h40);
    add_mid(8'h40, 0);
    @(negedge clk); in_valid = 1'b0; in_kind = 2'd2; in_word = 32'hFFFF_0000;
    @(negedge clk); in_valid = 1'b0; in_kind = 2'd1; in_word = 32'h0BAD_0BAD;
    add_mid(8'h40, 1);
    add_mid(8'h40, 2);
    end_group(8'h40);
    idle(LAT + 4);

    // R6: marker while a group is open (one chunk of the old group in flight)
    begin_group(8'h77);
    for (int i = 0; i < 5; i++) add_mid(8'h77, i);
    run_group(8'h30, 2);
    idle(LAT + 4);

    // R8 R9: save mid-group, run another group, restore, finish
    begin_group(8'h21);
    for (int i = 0; i < 4; i++) add_mid(8'h21, i);
    @(negedge clk); in_valid = 1'b0; ctx_save = 1'b1;
    #1;
    check(ctx_busy == 1'b1, "R8", "busy with chunks in flight", 128'(ctx_busy), 128'(1));
    begin
      int w = 0;
      while (ctx_busy && w < 100) begin @(negedge clk); #1; w++; end
      check(ctx_vld == 1'b0, "R8", "no save while busy", 128'(ctx_vld), 128'(0));
    end
    @(negedge clk);
    ctx_save = 1'b0;
    check(ctx_vld == 1'b1, "R8", "save strobe", 128'(ctx_vld), 128'(1));
    snap = ctx_out;
    begin
      logic [31:0] keep_w [0:31];
      int keep_n;
      keep_n = gn;
      for (int i = 0; i < gn; i++) keep_w[i] = gw[i];
      run_group(8'h22, 3);
      idle(LAT + 4);
      @(negedge clk); ctx_load = 1'b1; ctx_in = snap;
      @(negedge clk); ctx_load = 1'b0;
      gn = keep_n;
      for (int i = 0; i < gn; i++) gw[i] = keep_w[i];
    end
    add_mid(8'h21, 4);
    end_group(8'h21);
    idle(LAT + 4);

    // R10: group cut by reset yields nothing
    begin_group(8'h55);
    add_mid(8'h55, 0);
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    drv(2'd2, 32'hE700_0011);
    idle(LAT + 4);
    check(!out_valid && !ctx_vld, "R10", "after reset cut", {out_valid, ctx_vld}, '0);

    // R5 R6 R10: every expected digest arrived, nothing extra
    check(e_rd == e_wr, "R6", "digest count", 128'(e_rd), 128'(e_wr));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule